// File: doc/BRIEF.md
# Ownership Update Coherence Controller

This block is the coherence engine of one private, direct-mapped snoop cache on a shared bus. Each line is modelled as a single data word. A line is either absent or held in one of four states: owned exclusive, owned sharable, unowned exclusive or unowned sharable. Being the owner means two things. The line must be written back when it is replaced. The cache must also hand its copy straight to another cache that reads the line over the bus. A line that is not owned may hold a value that differs from memory, and it is still dropped silently when replaced.

The processor sends one request at a time. The controller turns it into a local hit, or into a sequence of bus transactions: a write-back of an owned victim, a read fill, and a word update that is broadcast to other holders. Traffic from other caches arrives on the snoop port. The controller answers it one cycle later with a shared flag and, when it owns the line, the data. Processor requests use valid/ready. `cpu_req_ready` is high only while the controller is idle. A request is taken on the first edge where valid and ready are both high. There is exactly one `cpu_rsp_valid` pulse per request, and it has no back-pressure. A bus request is held stable until `bus_req_ready` grants it. After the grant, the bus returns exactly one `bus_rsp_valid` on a later cycle. Snoops cannot be held off.

Top module: `coh_update_ctrl`

## Requirements
- R1: After reset every line is absent. `cpu_req_ready` is 1 and `bus_req_valid`, `cpu_rsp_valid` and `snp_rsp_valid` are 0. A first read of any address issues a bus read.
- R2: A read miss issues op 0 (read) with the request address and data 0. The line fills as unowned sharable if `bus_rsp_shared` is 1, otherwise as unowned exclusive. The response returns the bus data. A later read hit returns the data with no bus traffic.
- R3: A write hitting an unowned-exclusive or owned-exclusive line makes it owned exclusive and stores the word, with no bus transaction.
- R4: A write hitting a sharable line (owned or unowned) issues op 1 (update) carrying the address and the word. The line becomes owned sharable if the update response is shared, otherwise owned exclusive. A write miss first fills the line (R2), then follows R3 or R4.
- R5: A snoop read (snp_op 0) hitting the line answers shared=1. If the line is owned, it also answers supply=1 with the line data and owned exclusive becomes owned sharable. If the line is unowned, it answers supply=0 with data 0 and unowned exclusive becomes unowned sharable.
- R6: A snoop update (snp_op 1) hitting the line replaces its word and leaves it unowned sharable, so a former owner gives up ownership. The answer is shared=1 and supply=0.
- R7: A miss whose slot holds an owned line first issues op 2 (write-back) with the victim's address and word, then the read. An unowned victim, even one changed by a snoop update, is replaced with no write-back.
- R8: A snoop whose tag does not match, or whose slot is absent, answers shared=0, supply=0, data 0 and changes nothing.
- R9: A snoop in the same cycle as a pending directory lookup, install or commit takes priority. The processor side waits one cycle and then acts on the state the snoop left.
- R10: Exactly one `cpu_rsp_valid` pulse follows each accepted request. It carries the read word, or the written word for a write. `cpu_req_ready` is low while any bus request is pending.
- R11: `bus_req_valid` with op, address and data stays stable until granted. At most one bus transaction is outstanding. Address bits [IDX_W-1:0] select the slot and the upper bits form the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller idle, request taken |
| cpu_req_write | input | 1 | 1 write, 0 read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_rsp_valid | output | 1 | Completion pulse |
| cpu_rsp_rdata | output | DATA_W | Read word or written word |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_ready | input | 1 | Grant |
| bus_req_op | output | 2 | 0 read, 1 update, 2 write-back |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_data | output | DATA_W | Update or write-back word, 0 for read |
| bus_rsp_valid | input | 1 | Transaction completion |
| bus_rsp_shared | input | 1 | Another cache holds the line |
| bus_rsp_data | input | DATA_W | Fill word for a read |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 1 | 0 read, 1 update |
| snp_addr | input | ADDR_W | Snooped address |
| snp_data | input | DATA_W | Snooped update word |
| snp_rsp_valid | output | 1 | Snoop answer, one cycle after snp_valid |
| snp_rsp_shared | output | 1 | Line held here |
| snp_rsp_supply | output | 1 | This cache owns and supplies the line |
| snp_rsp_data | output | DATA_W | Supplied word |

## Verification
The snoop port and the processor's directory access can land in the same cycle. The bench provokes this by raising a snoop in the cycle right after a request is accepted, while the lookup is pending. One case is a snoop read against an owned-exclusive line that the processor is writing. Priority is judged from the ports: the write must now emit a bus update, because the snoop already made the line sharable. The snoop answer must supply the pre-write word. A second case is a snoop update colliding with a read hit. There the processor must receive the snooped word.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    LN_INV = 3'd0,
    LN_UE  = 3'd1,
    LN_US  = 3'd2,
    LN_OE  = 3'd3,
    LN_OS  = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    BOP_READ   = 2'd0,
    BOP_UPDATE = 2'd1,
    BOP_WBACK  = 2'd2
  } bus_op_e;

  typedef enum logic [2:0] {
    F_IDLE, F_LOOK, F_WB, F_FILL, F_INST, F_UPD, F_COMMIT
  } ctl_fsm_e;

  function automatic logic st_owned(line_st_e s);
    return (s == LN_OE) || (s == LN_OS);
  endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 12,
  parameter int DATA_W = 32,
  localparam int SETS  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor-side lookup port
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  // snoop-side lookup port
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  // snoop write (state and word only), wins on a conflict
  input  logic              s_we,
  input  logic [IDX_W-1:0]  s_idx,
  input  line_st_e          s_st,
  input  logic [DATA_W-1:0] s_data,
  // controller write (state, tag and word)
  input  logic              c_we,
  input  logic [IDX_W-1:0]  c_idx,
  input  line_st_e          c_st,
  input  logic [TAG_W-1:0]  c_tag,
  input  logic [DATA_W-1:0] c_data
);

  line_st_e          st_q   [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  logic c_go;
  assign c_go = c_we && !(s_we && (s_idx == c_idx));

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= LN_INV;
    end else begin
      if (s_we) st_q[s_idx] <= s_st;
      if (c_go) st_q[c_idx] <= c_st;
    end
  end

  always_ff @(posedge clk) begin
    if (s_we) data_q[s_idx] <= s_data;
    if (c_go) begin
      data_q[c_idx] <= c_data;
      tag_q[c_idx]  <= c_tag;
    end
  end

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic              snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  output logic [IDX_W-1:0]  lk_idx,
  input  line_st_e          lk_st,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [DATA_W-1:0] lk_data,
  output logic              wr_en,
  output line_st_e          wr_st,
  output logic [DATA_W-1:0] wr_data,
  output logic              rsp_valid,
  output logic              rsp_shared,
  output logic              rsp_supply,
  output logic [DATA_W-1:0] rsp_data
);

  logic hit, supply;

  assign lk_idx = snp_addr[IDX_W-1:0];
  assign hit    = snp_valid && (lk_st != LN_INV) && (lk_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign supply = hit && !snp_op && st_owned(lk_st);

  always_comb begin
    wr_en   = 1'b0;
    wr_st   = lk_st;
    wr_data = lk_data;
    if (hit) begin
      if (snp_op) begin
        // another cache wrote the word: take it and lose any ownership
        wr_en   = 1'b1;
        wr_st   = LN_US;
        wr_data = snp_data;
      end else if (lk_st == LN_OE) begin
        wr_en = 1'b1;
        wr_st = LN_OS;
      end else if (lk_st == LN_UE) begin
        wr_en = 1'b1;
        wr_st = LN_US;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_shared <= 1'b0;
      rsp_supply <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid  <= snp_valid;
      rsp_shared <= hit;
      rsp_supply <= supply;
      rsp_data   <= supply ? lk_data : '0;
    end
  end

endmodule

// File: rtl/coh_proc_fsm.sv
module coh_proc_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_op,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_shared,
  input  logic [DATA_W-1:0] bus_rsp_data,
  input  logic              snp_busy,
  output logic [IDX_W-1:0]  ln_idx,
  input  line_st_e          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              wr_en,
  output line_st_e          wr_st,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);

  ctl_fsm_e          fsm_q;
  logic              req_wr_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              issued_q;
  logic              shr_q;
  logic [DATA_W-1:0] fill_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [DATA_W-1:0] wb_data_q;
  logic              rsp_v_q;
  logic [DATA_W-1:0] rsp_d_q;

  logic [TAG_W-1:0] req_tag;
  logic             ln_hit, ln_excl, dir_free, bus_done;

  assign ln_idx   = req_addr_q[IDX_W-1:0];
  assign req_tag  = req_addr_q[ADDR_W-1:IDX_W];
  assign ln_hit   = (ln_st != LN_INV) && (ln_tag == req_tag);
  assign ln_excl  = (ln_st == LN_UE) || (ln_st == LN_OE);
  assign dir_free = !snp_busy;
  assign bus_done = issued_q && bus_rsp_valid;

  assign cpu_req_ready = (fsm_q == F_IDLE);
  assign cpu_rsp_valid = rsp_v_q;
  assign cpu_rsp_rdata = rsp_d_q;

  // bus request drive
  always_comb begin
    bus_req_valid = 1'b0;
    bus_req_op    = BOP_READ;
    bus_req_addr  = '0;
    bus_req_data  = '0;
    unique case (fsm_q)
      F_WB: begin
        bus_req_valid = !issued_q;
        bus_req_op    = BOP_WBACK;
        bus_req_addr  = wb_addr_q;
        bus_req_data  = wb_data_q;
      end
      F_FILL: begin
        bus_req_valid = !issued_q;
        bus_req_op    = BOP_READ;
        bus_req_addr  = req_addr_q;
      end
      F_UPD: begin
        bus_req_valid = !issued_q;
        bus_req_op    = BOP_UPDATE;
        bus_req_addr  = req_addr_q;
        bus_req_data  = req_wdata_q;
      end
      default: ;
    endcase
  end

  // directory writes happen only in cycles the snoop port leaves free
  always_comb begin
    wr_en   = 1'b0;
    wr_st   = LN_INV;
    wr_tag  = req_tag;
    wr_data = req_wdata_q;
    unique case (fsm_q)
      F_LOOK: if (dir_free && ln_hit && req_wr_q && ln_excl) begin
        wr_en = 1'b1;
        wr_st = LN_OE;
      end
      F_INST: if (dir_free) begin
        wr_en   = 1'b1;
        wr_st   = shr_q ? LN_US : LN_UE;
        wr_data = fill_q;
      end
      F_COMMIT: if (dir_free) begin
        wr_en = 1'b1;
        wr_st = shr_q ? LN_OS : LN_OE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q       <= F_IDLE;
      req_wr_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      issued_q    <= 1'b0;
      shr_q       <= 1'b0;
      fill_q      <= '0;
      wb_addr_q   <= '0;
      wb_data_q   <= '0;
      rsp_v_q     <= 1'b0;
      rsp_d_q     <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      if (bus_req_valid && bus_req_ready) issued_q <= 1'b1;
      unique case (fsm_q)
        F_IDLE: if (cpu_req_valid) begin
          req_wr_q    <= cpu_req_write;
          req_addr_q  <= cpu_req_addr;
          req_wdata_q <= cpu_req_wdata;
          fsm_q       <= F_LOOK;
        end
        F_LOOK: if (dir_free) begin
          issued_q <= 1'b0;
          if (ln_hit) begin
            if (!req_wr_q) begin
              rsp_v_q <= 1'b1;
              rsp_d_q <= ln_data;
              fsm_q   <= F_IDLE;
            end else if (ln_excl) begin
              rsp_v_q <= 1'b1;
              rsp_d_q <= req_wdata_q;
              fsm_q   <= F_IDLE;
            end else begin
              fsm_q <= F_UPD;
            end
          end else if (st_owned(ln_st)) begin
            wb_addr_q <= {ln_tag, ln_idx};
            wb_data_q <= ln_data;
            fsm_q     <= F_WB;
          end else begin
            fsm_q <= F_FILL;
          end
        end
        F_WB: if (bus_done) begin
          issued_q <= 1'b0;
          fsm_q    <= F_FILL;
        end
        F_FILL: if (bus_done) begin
          issued_q <= 1'b0;
          fill_q   <= bus_rsp_data;
          shr_q    <= bus_rsp_shared;
          fsm_q    <= F_INST;
        end
        F_INST: if (dir_free) fsm_q <= F_LOOK;
        F_UPD: if (bus_done) begin
          issued_q <= 1'b0;
          shr_q    <= bus_rsp_shared;
          fsm_q    <= F_COMMIT;
        end
        F_COMMIT: if (dir_free) begin
          rsp_v_q <= 1'b1;
          rsp_d_q <= req_wdata_q;
          fsm_q   <= F_IDLE;
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/coh_update_ctrl.sv
module coh_update_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_op,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_shared,
  input  logic [DATA_W-1:0] bus_rsp_data,
  input  logic              snp_valid,
  input  logic              snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  output logic              snp_rsp_valid,
  output logic              snp_rsp_shared,
  output logic              snp_rsp_supply,
  output logic [DATA_W-1:0] snp_rsp_data
);

  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx;
  line_st_e          a_st, b_st, snp_wst, ctl_wst;
  logic [TAG_W-1:0]  a_tag, b_tag, ctl_wtag;
  logic [DATA_W-1:0] a_data, b_data, snp_wdata, ctl_wdata;
  logic              snp_we, ctl_we;

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .s_we(snp_we), .s_idx(b_idx), .s_st(snp_wst), .s_data(snp_wdata),
    .c_we(ctl_we), .c_idx(a_idx), .c_st(ctl_wst), .c_tag(ctl_wtag), .c_data(ctl_wdata)
  );

  coh_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr), .snp_data(snp_data),
    .lk_idx(b_idx), .lk_st(b_st), .lk_tag(b_tag), .lk_data(b_data),
    .wr_en(snp_we), .wr_st(snp_wst), .wr_data(snp_wdata),
    .rsp_valid(snp_rsp_valid), .rsp_shared(snp_rsp_shared),
    .rsp_supply(snp_rsp_supply), .rsp_data(snp_rsp_data)
  );

  coh_proc_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_op(bus_req_op), .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_shared(bus_rsp_shared),
    .bus_rsp_data(bus_rsp_data),
    .snp_busy(snp_valid),
    .ln_idx(a_idx), .ln_st(a_st), .ln_tag(a_tag), .ln_data(a_data),
    .wr_en(ctl_we), .wr_st(ctl_wst), .wr_tag(ctl_wtag), .wr_data(ctl_wdata)
  );

endmodule

// File: rtl/coh_update_ctrl_chk.sv
module coh_update_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic [1:0]        bus_req_op,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic [DATA_W-1:0] bus_req_data,
  input logic              snp_valid,
  input logic              snp_rsp_valid,
  input logic              snp_rsp_shared,
  input logic              snp_rsp_supply,
  input logic              snp_we,
  input logic              ctl_we
);

  logic outst_q;
  always_ff @(posedge clk) begin
    if (!rst_n) outst_q <= 1'b0;
    else if (cpu_req_valid && cpu_req_ready) outst_q <= 1'b1;
    else if (cpu_rsp_valid) outst_q <= 1'b0;
  end

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_op)
      && $stable(bus_req_addr) && $stable(bus_req_data));

  // R10
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !cpu_req_ready);

  // R10
  rsp_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> outst_q);

  // R10
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |-> !outst_q || cpu_rsp_valid);

  // R5
  supply_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_rsp_valid && snp_rsp_supply |-> snp_rsp_shared);

  // R8
  snp_rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_rsp_valid |-> $past(snp_valid));

  // R9
  no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_we && ctl_we));

endmodule

bind coh_update_ctrl coh_update_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid),
  .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
  .bus_req_op(bus_req_op), .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
  .snp_valid(snp_valid), .snp_rsp_valid(snp_rsp_valid),
  .snp_rsp_shared(snp_rsp_shared), .snp_rsp_supply(snp_rsp_supply),
  .snp_we(snp_we), .ctl_we(ctl_we)
);

// File: tb/coh_update_ctrl_bench.sv
module coh_update_ctrl_bench;

  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic bus_req_valid;
  logic bus_req_ready = 1'b0;
  logic [1:0] bus_req_op;
  logic [AW-1:0] bus_req_addr;
  logic [DW-1:0] bus_req_data;
  logic bus_rsp_valid = 1'b0, bus_rsp_shared = 1'b0;
  logic [DW-1:0] bus_rsp_data = '0;
  logic snp_valid = 1'b0, snp_op = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_data = '0;
  logic snp_rsp_valid, snp_rsp_shared, snp_rsp_supply;
  logic [DW-1:0] snp_rsp_data;

  always #4 clk = ~clk;

  coh_update_ctrl u_coh_update_ctrl (.*);

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  // reference model: 0 absent, 1 UE, 2 US, 3 OE, 4 OS
  int          m_st   [16];
  logic [11:0] m_tag  [16];
  logic [31:0] m_data [16];
  logic [31:0] mem [int];
  int          q_op[$];
  logic [15:0] q_addr[$];
  logic [31:0] q_data[$];
  logic [31:0] q_fill[$];
  bit          e_sh, e_su;
  logic [31:0] e_sd;

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return {16'hC0DE, a};
  endfunction

  function automatic void model_snoop(bit op, logic [15:0] a, logic [31:0] d);
    int i = int'(a[3:0]);
    bit hit = (m_st[i] != 0) && (m_tag[i] == a[15:4]);
    e_sh = hit;
    e_su = hit && !op && (m_st[i] >= 3);
    e_sd = e_su ? m_data[i] : 32'h0;
    if (hit) begin
      if (op) begin m_st[i] = 2; m_data[i] = d; end
      else if (m_st[i] == 3) m_st[i] = 4;
      else if (m_st[i] == 1) m_st[i] = 2;
    end
  endfunction

  function automatic logic [31:0] model_cpu(bit wr, logic [15:0] a, logic [31:0] wd, bit shr);
    int i = int'(a[3:0]);
    if (!((m_st[i] != 0) && (m_tag[i] == a[15:4]))) begin
      if (m_st[i] >= 3) begin
        q_op.push_back(2); q_addr.push_back({m_tag[i], a[3:0]});
        q_data.push_back(m_data[i]); q_fill.push_back(32'h0);
        mem[int'({m_tag[i], a[3:0]})] = m_data[i];
      end
      q_op.push_back(0); q_addr.push_back(a); q_data.push_back(32'h0);
      q_fill.push_back(mem_rd(a));
      m_st[i] = shr ? 2 : 1; m_tag[i] = a[15:4]; m_data[i] = mem_rd(a);
    end
    if (!wr) return m_data[i];
    if (m_st[i] == 1 || m_st[i] == 3) m_st[i] = 3;
    else begin
      q_op.push_back(1); q_addr.push_back(a); q_data.push_back(wd); q_fill.push_back(32'h0);
      m_st[i] = shr ? 4 : 3;
    end
    m_data[i] = wd;
    return wd;
  endfunction

  task automatic snoop(string r, bit op, logic [15:0] a, logic [31:0] d);
    model_snoop(op, a, d);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = a; snp_data = d;
    @(posedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
    chk(r, "snoop shared", {31'h0, snp_rsp_shared}, {31'h0, e_sh});
    chk(r, "snoop supply", {31'h0, snp_rsp_supply}, {31'h0, e_su});
    chk(r, "snoop data", snp_rsp_data, e_sd);
  endtask

  // processor request; optional snoop raised in the lookup cycle
  task automatic cpu_op(string r, bit wr, logic [15:0] a, logic [31:0] wd, bit shr,
                        bit s_en = 0, bit s_op = 0, logic [15:0] s_a = 0, logic [31:0] s_d = 0);
    logic [31:0] exp_rd;
    bit done = 0;
    if (s_en) model_snoop(s_op, s_a, s_d);
    exp_rd = model_cpu(wr, a, wd, shr);
    @(negedge clk);
    chk("R10", "ready when idle", {31'h0, cpu_req_ready}, 32'h1);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (s_en) begin
      snp_valid = 1'b1; snp_op = s_op; snp_addr = s_a; snp_data = s_d;
      @(posedge clk);
      @(negedge clk);
      snp_valid = 1'b0;
      chk("R9", "collided snoop shared", {31'h0, snp_rsp_shared}, {31'h0, e_sh});
      chk("R9", "collided snoop supply", {31'h0, snp_rsp_supply}, {31'h0, e_su});
      chk("R9", "collided snoop data", snp_rsp_data, e_sd);
    end
    for (int n = 0; n < 60 && !done; n++) begin
      if (cpu_rsp_valid) begin
        chk(r, "cpu response data", cpu_rsp_rdata, exp_rd);
        chk("R10", "idle at response", {31'h0, cpu_req_ready}, 32'h1);
        done = 1;
      end else if (bus_req_valid) begin
        if (q_op.size() == 0) begin
          chk(r, "unexpected bus op", {30'h0, bus_req_op}, 32'hFFFF_FFFF);
          q_op.push_back(9); q_addr.push_back(0); q_data.push_back(0); q_fill.push_back(0);
        end
        chk(r, "bus op", {30'h0, bus_req_op}, q_op[0]);
        chk(r, "bus addr", {16'h0, bus_req_addr}, {16'h0, q_addr[0]});
        chk(r, "bus data", bus_req_data, q_data[0]);
        bus_req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_req_ready = 1'b0;
        bus_rsp_valid = 1'b1; bus_rsp_shared = shr; bus_rsp_data = q_fill[0];
        void'(q_op.pop_front()); void'(q_addr.pop_front());
        void'(q_data.pop_front()); void'(q_fill.pop_front());
        @(posedge clk);
        @(negedge clk);
        bus_rsp_valid = 1'b0;
      end else begin
        @(posedge clk);
        @(negedge clk);
      end
    end
    if (!done) chk("R10", "response timeout", 32'h0, 32'h1);
    chk(r, "missing bus ops", q_op.size(), 0);
    q_op.delete(); q_addr.delete(); q_data.delete(); q_fill.delete();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_st[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "ready after reset", {31'h0, cpu_req_ready}, 32'h1);
    chk("R1", "bus idle after reset", {31'h0, bus_req_valid}, 32'h0);
    chk("R1", "no rsp after reset", {31'h0, cpu_rsp_valid}, 32'h0);
    chk("R1", "no snoop rsp after reset", {31'h0, snp_rsp_valid}, 32'h0);

    cpu_op("R1", 0, 16'h0011, 0, 0);                 // miss -> UE
    cpu_op("R2", 0, 16'h0011, 0, 0);                 // hit
    snoop("R5", 0, 16'h0011, 0);                     // UE -> US, no supply
    cpu_op("R4", 1, 16'h0011, 32'h1111_0001, 1);     // US -> update -> OS
    snoop("R5", 0, 16'h0011, 0);                     // OS supplies
    snoop("R6", 1, 16'h0011, 32'h6666_0006);         // owner drops to US
    cpu_op("R6", 0, 16'h0011, 0, 0);                 // reads snooped word
    cpu_op("R7", 0, 16'h0021, 0, 1);                 // US victim, no write-back
    cpu_op("R2", 0, 16'h0032, 0, 0);                 // UE
    cpu_op("R3", 1, 16'h0032, 32'h3333_0003, 0);     // UE -> OE silently
    cpu_op("R3", 1, 16'h0032, 32'h3333_0004, 0);     // OE stays OE
    snoop("R5", 0, 16'h0032, 0);                     // OE -> OS supply
    snoop("R8", 0, 16'h0F32, 0);                     // tag miss
    snoop("R8", 1, 16'h0005, 32'hDEAD_0000);         // absent slot
    snoop("R8", 0, 16'h0032, 0);                     // still owned
    cpu_op("R7", 0, 16'h0042, 0, 0);                 // OS victim -> write-back
    cpu_op("R4", 1, 16'h0053, 32'h5555_0005, 1);     // write miss, update
    cpu_op("R7", 1, 16'h0063, 32'h6363_0001, 0);     // OS victim, fill UE, local write
    cpu_op("R9", 1, 16'h0063, 32'h6363_0002, 1, 1, 0, 16'h0063, 0);
    snoop("R6", 1, 16'h0063, 32'h6363_0099);         // OS owner loses line
    cpu_op("R7", 0, 16'h0083, 0, 0);                 // US victim, no write-back
    cpu_op("R2", 0, 16'h0074, 0, 0);
    cpu_op("R9", 0, 16'h0074, 0, 0, 1, 1, 16'h0074, 32'h7474_00AA);
    cpu_op("R4", 1, 16'h0074, 32'h7474_00BB, 0);     // US update, unshared -> OE
    snoop("R5", 0, 16'h0074, 0);
    for (int k = 0; k < 8; k++) begin
      cpu_op("R2", 0, 16'h0100 + 16'(k * 17), 0, k[0]);
      cpu_op("R4", 1, 16'h0100 + 16'(k * 17), 32'hA000_0000 + k, k[1]);
      snoop("R5", 0, 16'h0100 + 16'(k * 17), 0);
    end
    for (int k = 0; k < 8; k++) cpu_op("R7", 0, 16'h0200 + 16'(k * 17), 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog actual=%0d expected=<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule